// File: doc/BRIEF.md
# Serial Converter Read Sequencer

This block is the host-side controller for a 12-bit successive-approximation converter whose serial clock is supplied by the host. It issues convert pulses at a programmable rate and follows the converter's busy line. It generates bursts of serial clock to pull in each result, MSB first, and hands every collected word to a downstream consumer. The word is a 12-bit two's-complement value sign-extended to 16 bits.

Three read policies are selectable. An after-conversion read clocks the whole word once busy rises. A next-conversion read clocks the whole word right after the following convert pulse, before the converter's noise-sensitive window opens. A split read takes a programmable number of leading bits after busy rises and the rest after the next convert pulse. Every clock burst is placed so that the serial clock is quiet through the sensitive window and low while the converter moves its result into its output register. The burst also always ends before a new convert pulse is issued. All time limits are parameters counted in system clock cycles.

The result interface is valid/ready. `res_data` is held stable while `res_valid` is high and `res_ready` is low. While a word waits, no new convert pulse is issued, so a word is never overwritten. With `res_ready` tied high, `res_valid` is a one-cycle strobe.

Top module: `adc_read_seq`

## Requirements
- R1: While reset is asserted and after it is released, `conv_n` is high, `sclk` is low and `res_valid` is low until a conversion has been read.
- R2: Each convert pulse holds `conv_n` low for exactly CONV_LOW clock cycles.
- R3: Successive falling edges of `conv_n` are separated by exactly max(`conv_interval`, MIN_CYCLE) cycles, provided no read or output stall is pending. They are never separated by fewer than MIN_CYCLE cycles.
- R4: With `mode` = 0 (after-conversion; `mode` = 3 behaves the same), twelve serial clocks follow each rising edge of `busy_n`. The word they collect is the result of the conversion that just ended.
- R5: With `mode` = 1 (next-conversion), the twelve clocks start when a convert pulse ends and collect the previous conversion's result. The first conversion after `enable` rises yields no word.
- R6: With `mode` = 2 (split), `split_bits` = K clocks follow each busy rise and 12-K clocks follow the next convert pulse, together forming one word. K = 0 acts as mode 1, and K of 12 or more acts as mode 0.
- R7: The serial clock stays high for SCLK_HI cycles and low for at least SCLK_LO cycles. `sdata` is captured at each falling edge of `sclk` and shifted in MSB first.
- R8: `sclk` is low from QUIET cycles after a falling edge of `conv_n` until `busy_n` rises. It is also low whenever `conv_n` falls.
- R9: `res_data` is the 12-bit word sign-extended to 16 bits. It is held with `res_valid` until `res_ready`, and no convert pulse is issued while a word waits.
- R10: With `enable` low, no new convert pulse is issued, and a partially read word is discarded.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low reset |
| enable | input | 1 | Allows new convert pulses |
| mode | input | 2 | Read policy: 0 after, 1 next, 2 split |
| split_bits | input | BITS_W | Bits read after busy rises in split mode |
| conv_interval | input | CNT_W | Requested cycles between convert pulses |
| conv_n | output | 1 | Convert pulse to converter, active low |
| busy_n | input | 1 | Converter busy, low while converting |
| sclk | output | 1 | Serial clock to converter |
| sdata | input | 1 | Serial data from converter |
| res_valid | output | 1 | Word available |
| res_ready | input | 1 | Consumer accepts word |
| res_data | output | OUT_W | Sign-extended result |

## Verification
The embedded properties check several limits on every cycle: the convert pulse width, the minimum convert spacing, the serial clock phase widths, the silent clock after the quiet window, the low clock at convert, and that a held word stays stable and is never overrun. Only the bench's converter model can show that the right bits arrive in the right word. That covers each read policy, every split point from 0 to 12 and beyond, and words spanning two conversions. The bench also shows the exact rate, the dropped first word in next-conversion mode, and that a disabled run discards its partial word.

// File: rtl/adc_read_seq_pkg.sv
`timescale 1ns/1ps
package adc_read_seq_pkg;
  typedef enum logic [1:0] {
    RD_AFTER = 2'd0,
    RD_NEXT  = 2'd1,
    RD_SPLIT = 2'd2
  } rd_mode_e;

  typedef enum logic [1:0] {
    ST_IDLE,
    ST_CONV,
    ST_WAITB,
    ST_POST
  } seq_st_e;
endpackage

// File: rtl/ars_sync.sv
`timescale 1ns/1ps
module ars_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic d,
  output logic q
);
  logic [STAGES-1:0] st;

  generate
    if (STAGES == 1) begin : g_one
      always_ff @(posedge clk or negedge rst_n)
        if (!rst_n) st <= '1;
        else        st <= d;
    end else begin : g_many
      always_ff @(posedge clk or negedge rst_n)
        if (!rst_n) st <= '1;
        else        st <= {st[STAGES-2:0], d};
    end
  endgenerate

  assign q = st[STAGES-1];
endmodule

// File: rtl/ars_sclk.sv
`timescale 1ns/1ps
module ars_sclk #(
  parameter int SCLK_HI = 5,
  parameter int SCLK_LO = 5,
  parameter int BITS_W  = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic [BITS_W-1:0] nbits,
  output logic              sclk,
  output logic              take,
  output logic              active
);
  localparam int PH_MAX = (SCLK_HI > SCLK_LO) ? SCLK_HI : SCLK_LO;
  localparam int PH_W   = $clog2(PH_MAX + 1);

  logic [PH_W-1:0]   ph;
  logic [BITS_W-1:0] left;

  assign take = active && sclk && (ph == PH_W'(SCLK_HI - 1));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      active <= 1'b0;
      sclk   <= 1'b0;
      ph     <= '0;
      left   <= '0;
    end else if (start && !active) begin
      active <= 1'b1;
      sclk   <= 1'b1;
      ph     <= '0;
      left   <= nbits;
    end else if (active) begin
      if (sclk) begin
        if (ph == PH_W'(SCLK_HI - 1)) begin
          sclk <= 1'b0;
          ph   <= '0;
          left <= left - 1'b1;
        end else ph <= ph + 1'b1;
      end else begin
        if (ph == PH_W'(SCLK_LO - 1)) begin
          ph <= '0;
          if (left == '0) active <= 1'b0;
          else            sclk   <= 1'b1;
        end else ph <= ph + 1'b1;
      end
    end
  end

  logic [7:0] hi_run, lo_run;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hi_run <= '0;
      lo_run <= '1;
    end else begin
      hi_run <= sclk ? hi_run + 1'b1 : '0;
      lo_run <= sclk ? '0 : ((lo_run == '1) ? lo_run : lo_run + 1'b1);
    end
  end

  // R7
  sclk_high_width_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(sclk) |-> hi_run == 8'(SCLK_HI));
  // R7
  sclk_low_width_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(sclk) |-> lo_run >= 8'(SCLK_LO));
  // R7
  sclk_bit_budget_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (active && sclk) |-> left != '0);
endmodule

// File: rtl/ars_shift.sv
`timescale 1ns/1ps
module ars_shift #(
  parameter int WORD_W = 12
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              take,
  input  logic              sdata,
  output logic [WORD_W-1:0] word_now
);
  logic [WORD_W-1:0] sr;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n)    sr <= '0;
    else if (take) sr <= word_now;

  assign word_now = {sr[WORD_W-2:0], sdata};
endmodule

// File: rtl/adc_read_seq.sv
`timescale 1ns/1ps
module adc_read_seq
  import adc_read_seq_pkg::*;
#(
  parameter int WORD_W    = 12,
  parameter int OUT_W     = 16,
  parameter int CNT_W     = 16,
  parameter int BITS_W    = $clog2(WORD_W + 1),
  parameter int MIN_CYCLE = 2500,
  parameter int CONV_LOW  = 10,
  parameter int QUIET     = 800,
  parameter int SCLK_HI   = 5,
  parameter int SCLK_LO   = 5,
  parameter int SYNC_ST   = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              enable,
  input  logic [1:0]        mode,
  input  logic [BITS_W-1:0] split_bits,
  input  logic [CNT_W-1:0]  conv_interval,
  output logic              conv_n,
  input  logic              busy_n,
  output logic              sclk,
  input  logic              sdata,
  output logic              res_valid,
  input  logic              res_ready,
  output logic [OUT_W-1:0]  res_data
);
  localparam int PAD_W = OUT_W - WORD_W;
  localparam logic [BITS_W-1:0] FULL = BITS_W'(WORD_W);

  seq_st_e           state;
  logic              busy_s, seen_low, rem_armed;
  logic [CNT_W-1:0]  since_start, lowcnt, eff_int;
  logic [BITS_W-1:0] rem_bits, a_bits, bits_got, burst_n;
  logic              burst_start, active, take, start_conv, conv_end, busy_rise, word_done;
  logic [WORD_W-1:0] word_now;

  ars_sync #(.STAGES(SYNC_ST)) u_sync (
    .clk(clk), .rst_n(rst_n), .d(busy_n), .q(busy_s));

  ars_sclk #(.SCLK_HI(SCLK_HI), .SCLK_LO(SCLK_LO), .BITS_W(BITS_W)) u_sclk (
    .clk(clk), .rst_n(rst_n), .start(burst_start), .nbits(burst_n),
    .sclk(sclk), .take(take), .active(active));

  ars_shift #(.WORD_W(WORD_W)) u_shift (
    .clk(clk), .rst_n(rst_n), .take(take), .sdata(sdata), .word_now(word_now));

  always_comb begin
    unique case (rd_mode_e'(mode))
      RD_NEXT:  a_bits = '0;
      RD_SPLIT: a_bits = (split_bits > FULL) ? FULL : split_bits;
      default:  a_bits = FULL;
    endcase
  end

  assign eff_int     = (conv_interval < CNT_W'(MIN_CYCLE)) ? CNT_W'(MIN_CYCLE) : conv_interval;
  assign start_conv  = (state == ST_IDLE) && enable && !res_valid && !active &&
                       (since_start >= eff_int - 1'b1);
  assign conv_end    = (state == ST_CONV) && (lowcnt == CNT_W'(CONV_LOW - 1));
  assign busy_rise   = (state == ST_WAITB) && seen_low && busy_s;
  assign burst_start = (conv_end && rem_armed && (rem_bits != '0)) ||
                       (busy_rise && (a_bits != '0));
  assign burst_n     = busy_rise ? a_bits : rem_bits;
  assign word_done   = take && (bits_got == FULL - 1'b1);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state       <= ST_IDLE;
      conv_n      <= 1'b1;
      since_start <= '1;
      lowcnt      <= '0;
      seen_low    <= 1'b0;
      rem_armed   <= 1'b0;
      rem_bits    <= '0;
    end else begin
      if (start_conv)              since_start <= '0;
      else if (since_start != '1)  since_start <= since_start + 1'b1;
      unique case (state)
        ST_IDLE: begin
          if (!enable) rem_armed <= 1'b0;
          if (start_conv) begin
            conv_n <= 1'b0;
            lowcnt <= '0;
            state  <= ST_CONV;
          end
        end
        ST_CONV: begin
          seen_low <= 1'b0;
          if (conv_end) begin
            conv_n    <= 1'b1;
            rem_armed <= 1'b0;
            state     <= ST_WAITB;
          end else lowcnt <= lowcnt + 1'b1;
        end
        ST_WAITB: begin
          if (!busy_s) seen_low <= 1'b1;
          if (busy_rise) begin
            rem_bits  <= FULL - a_bits;
            rem_armed <= (a_bits != FULL) && enable;
            state     <= ST_POST;
          end
        end
        default: if (!active) state <= ST_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) bits_got <= '0;
    else if (take) bits_got <= word_done ? '0 : bits_got + 1'b1;
    else if (state == ST_IDLE && !enable) bits_got <= '0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      res_valid <= 1'b0;
      res_data  <= '0;
    end else if (word_done) begin
      res_valid <= 1'b1;
      res_data  <= {{PAD_W{word_now[WORD_W-1]}}, word_now};
    end else if (res_ready) res_valid <= 1'b0;
  end

  logic [CNT_W-1:0] low_run, gap_cnt;
  logic             conv_d;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      low_run <= '0;
      gap_cnt <= '1;
      conv_d  <= 1'b1;
    end else begin
      conv_d  <= conv_n;
      low_run <= conv_n ? '0 : low_run + 1'b1;
      if (conv_d && !conv_n)   gap_cnt <= CNT_W'(1);
      else if (gap_cnt != '1)  gap_cnt <= gap_cnt + 1'b1;
    end
  end

  // R2
  conv_low_width_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(conv_n) |-> low_run == CNT_W'(CONV_LOW));
  // R3
  conv_spacing_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(conv_n) |-> gap_cnt >= CNT_W'(MIN_CYCLE));
  // R8
  quiet_window_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (state == ST_WAITB && since_start >= CNT_W'(QUIET)) |-> !sclk);
  // R8
  conv_sclk_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(conv_n) |-> !sclk);
  // R9
  hold_stable_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (res_valid && !res_ready) |=> (res_valid && $stable(res_data)));
  // R9
  no_overrun_chk: assert property (@(posedge clk) disable iff (!rst_n)
    word_done |-> (!res_valid || res_ready));
endmodule

// File: tb/sim_adc_read_seq.sv
`timescale 1ns/1ps
module sim_adc_read_seq;
  localparam int MIN_C   = 300;
  localparam int CLOW    = 4;
  localparam int QUIET_C = 80;
  localparam int HI      = 2;
  localparam int LO      = 2;
  localparam int CONV_T  = 150;
  localparam int GUARD   = 20;

  logic clk = 1'b0, rst_n = 1'b0;
  logic enable = 1'b0, busy_n = 1'b1, sdata = 1'b0, res_ready = 1'b1;
  logic [1:0] mode = 2'd0;
  logic [3:0] split = 4'd0;
  logic [15:0] conv_interval = 16'd0;
  logic conv_n, sclk, res_valid;
  logic [15:0] res_data;

  always #5 clk = ~clk;

  adc_read_seq #(.MIN_CYCLE(MIN_C), .CONV_LOW(CLOW), .QUIET(QUIET_C),
                 .SCLK_HI(HI), .SCLK_LO(LO)) u0 (
    .clk(clk), .rst_n(rst_n), .enable(enable), .mode(mode), .split_bits(split),
    .conv_interval(conv_interval), .conv_n(conv_n), .busy_n(busy_n), .sclk(sclk),
    .sdata(sdata), .res_valid(res_valid), .res_ready(res_ready), .res_data(res_data));

  int checks = 0, fails = 0, cyc = 0;
  int falls = 0, run_falls = 0, last_fall = 0, exp_gap = 0, words = 0;
  int low_run = 0, hi_run = 0, lo_run = 1000, last_hi = -1000;
  int v_width = 0, v_guard = 0, v_window = 0, v_convclk = 0, lost = 0;
  int m_idx = 0, bitcnt = 0;
  bit conv_prev = 1'b1, sclk_prev = 1'b0, done = 1'b0;
  string cur_req = "R4";
  logic [11:0] shreg = 12'h000;
  logic [11:0] q[$];

  task automatic chk(input bit ok, input string req, input string what,
                     input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  function automatic logic [11:0] mval(input int i);
    case (i % 6)
      0: mval = 12'h800;
      1: mval = 12'h7FF;
      2: mval = 12'h000;
      3: mval = 12'hFFF;
      default: mval = 12'((i * 1187 + 311) & 4095);
    endcase
  endfunction

  always @(posedge clk) cyc++;

  // converter model
  initial begin
    forever begin
      @(negedge conv_n);
      @(posedge clk); @(posedge clk); #1 busy_n = 1'b0;
      repeat (CONV_T) @(posedge clk);
      #1;
      if (cyc - last_hi < GUARD) v_guard++;
      if (!sclk) begin
        shreg = mval(m_idx);
        q.push_back(shreg);
        bitcnt = 0;
      end else lost++;
      m_idx++;
      busy_n = 1'b1;
    end
  end

  always @(posedge sclk) begin
    bitcnt++;
    sdata = (bitcnt <= 12) ? shreg[12 - bitcnt] : 1'b0;
  end

  // monitor
  always @(negedge clk) begin
    if (rst_n) begin
      if (conv_prev && !conv_n) begin
        falls++;
        // R3 exact spacing
        if (run_falls > 0 && exp_gap != 0)
          chk(cyc - last_fall == exp_gap, "R3", "convert spacing", cyc - last_fall, exp_gap);
        last_fall = cyc;
        run_falls++;
        if (sclk) v_convclk++;
      end
      // R2 pulse width
      if (!conv_prev && conv_n) chk(low_run == CLOW, "R2", "convert low width", low_run, CLOW);
      low_run = conv_n ? 0 : low_run + 1;
      conv_prev = conv_n;
      if (sclk_prev && !sclk && hi_run != HI) v_width++;
      if (!sclk_prev && sclk && lo_run < LO) v_width++;
      hi_run = sclk ? hi_run + 1 : 0;
      lo_run = sclk ? 0 : lo_run + 1;
      sclk_prev = sclk;
      if (sclk) last_hi = cyc;
      if (!busy_n && sclk && (cyc - last_fall) >= QUIET_C) v_window++;
      if (res_valid && res_ready) begin
        words++;
        if (q.size() == 0) chk(1'b0, cur_req, "word with no result", 0, 1);
        else begin
          logic [11:0] e;
          e = q.pop_front();
          // R9 sign extension
          chk(res_data == {{4{e[11]}}, e}, cur_req, "word value",
              int'(res_data), int'({{4{e[11]}}, e}));
        end
      end
    end
  end

  task automatic run(input logic [1:0] m, input logic [3:0] k, input int n,
                     input int ivl, input int gap, input int wexp, input string req);
    int target, f0;
    mode = m; split = k; conv_interval = 16'(ivl); exp_gap = gap;
    run_falls = 0; words = 0; cur_req = req;
    q.delete();
    @(negedge clk) enable = 1'b1;
    target = falls + n;
    while (falls < target) @(negedge clk);
    enable = 1'b0;
    repeat (500) @(negedge clk);
    chk(words == wexp, req, "words per run", words, wexp);
    f0 = falls;
    repeat (400) @(negedge clk);
    // R10 no convert while disabled
    chk(falls == f0, "R10", "converts while disabled", falls - f0, 0);
  endtask

  task automatic finish_sim();
    if (!done) begin
      done = 1'b1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    checks++; fails++;
    $display("FAIL watchdog expired actual=%0d expected=0", cyc);
    finish_sim();
  end

  initial begin
    logic [15:0] held;
    int f0;
    repeat (3) @(negedge clk);
    // R1 reset state
    chk(conv_n == 1'b1, "R1", "conv_n in reset", conv_n, 1);
    chk(sclk == 1'b0, "R1", "sclk in reset", sclk, 0);
    chk(res_valid == 1'b0, "R1", "res_valid in reset", res_valid, 0);
    rst_n = 1'b1;
    repeat (20) @(negedge clk);
    chk(conv_n == 1'b1 && res_valid == 1'b0, "R1", "idle after reset", res_valid, 0);

    run(2'd0, 4'd0, 5, 100, MIN_C, 5, "R4");   // after read, rate floor
    run(2'd3, 4'd0, 3, 0, MIN_C, 3, "R4");     // code 3 as after
    run(2'd1, 4'd0, 5, 400, 400, 4, "R5");     // next read, slower rate
    for (int k = 0; k <= 12; k++)              // R6 split sweep
      run(2'd2, 4'(k), 4, 0, MIN_C, (k == 12) ? 4 : 3, "R6");
    run(2'd2, 4'd15, 3, 0, MIN_C, 3, "R6");    // clamp above word size
    run(2'd0, 4'd0, 2, 350, 350, 2, "R4");     // R10 first word after split runs

    // R9 back-pressure
    mode = 2'd0; exp_gap = 0; conv_interval = 16'd0; res_ready = 1'b0;
    words = 0; cur_req = "R9"; q.delete();
    @(negedge clk) enable = 1'b1;
    while (!res_valid) @(negedge clk);
    held = res_data;
    f0 = falls;
    repeat (400) @(negedge clk);
    chk(res_valid == 1'b1, "R9", "valid held", res_valid, 1);
    chk(res_data == held, "R9", "data held", int'(res_data), int'(held));
    chk(falls == f0, "R9", "no convert while word waits", falls - f0, 0);
    enable = 1'b0;
    res_ready = 1'b1;
    repeat (400) @(negedge clk);
    chk(words == 1, "R9", "held word delivered once", words, 1);

    chk(v_width == 0, "R7", "sclk phase width violations", v_width, 0);
    chk(v_guard == 0, "R8", "sclk near busy rise", v_guard, 0);
    chk(v_window == 0, "R8", "sclk in quiet window", v_window, 0);
    chk(v_convclk == 0, "R8", "sclk high at convert", v_convclk, 0);
    chk(lost == 0, "R8", "results lost at update", lost, 0);
    finish_sim();
  end
endmodule